// File: doc/BRIEF.md
# I2C Slave with Control and Status Register

This block is a two-wire bus slave that owns a single 8-bit register. The upper six bits are control bits that software writes and the rest of the chip consumes on `ctrl_out`; the lower two bits are diagnostic flags. The flags come live from outside the block and cannot be written. The SCL and SDA lines are sampled on the system clock through a synchronizer with edge detection. START and STOP are decoded from SDA edges while SCL is high. SDA is never driven high: the block only asserts `sda_oe`, which the pad turns into a pull to ground.

The device address is a fixed five-bit prefix `00010` followed by two strap bits, so four copies can share one bus. A write carries exactly one data byte. A read returns the register again and again for as long as the master acknowledges. A lockout input, raised while the supply is too low, clears the register and keeps the slave silent on the bus.

No data stream passes through the block, so no valid/ready interface is used: every port is a plain level. The lockout input is expected to be synchronous to `clk`. SCL may run up to 500 kHz, provided `clk` is at least eight times the SCL rate.

Top module: `i2c_sysreg_slave`

## Requirements
- R1: After reset `ctrl_out` is all zero and `sda_oe` is low.
- R2: The slave answers the 7-bit address formed by `00010` followed by `addr_strap[1:0]`. Bit 0 of the address byte selects the direction: 0 means write and 1 means read.
- R3: On an address match the slave pulls SDA low for the whole ninth clock. It releases SDA after the falling edge of that clock, unless it is going on to send a read data bit of value 0.
- R4: On an address mismatch the slave never pulls SDA low, ignores the data bytes that follow, and stays passive until the next START.
- R5: In a write, the first data byte is acknowledged. Its bits 7..2 go to `ctrl_out[5:0]` (bit 7 to `ctrl_out[5]`), and its bits 1..0 are discarded. Any further data byte in the same transfer is not acknowledged and changes nothing.
- R6: In a read, each byte sent MSB first is `{ctrl_out[5:0], flag_otemp, flag_ovld}`. The two flags are captured when that byte is loaded, at the falling edge that ends the preceding acknowledge clock.
- R7: A master acknowledge after a read byte starts another byte. A master no-acknowledge makes the slave release SDA and stay passive until the next START.
- R8: While `uvlo` is high the register is held at zero and no acknowledge is given. A lockout that arrives during a write wins over the commit of that write.
- R9: `sda_oe` only rises while SCL is low.
- R10: A STOP at any point aborts the transfer without any register update, and a START at any point restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA to ground |
| addr_strap | input | 2 | Low two bits of the device address |
| uvlo | input | 1 | Supply lockout; clears the register and silences the slave |
| flag_otemp | input | 1 | Over-temperature flag, read back in bit 1 |
| flag_ovld | input | 1 | Overload flag, read back in bit 0 |
| ctrl_out | output | 6 | Control bits, register bits 7..2 |

## Verification
The lockout input and the write commit can arrive in the same cycle, because the commit fires at the synchronized SCL falling edge that ends the eighth data bit. The bench raises `uvlo` on the very edge where it drops SCL after the last data bit. Since the lockout is not synchronized, it reaches the logic ahead of or together with the delayed SCL edge. The case is judged at the ports: the ninth clock must show no acknowledge, `ctrl_out` must read zero, and a read after lockout is released must return zero control bits.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTRL_W = 6;
  localparam int unsigned STAT_W = BYTE_W - CTRL_W;
  localparam int unsigned DEV_W  = 7;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } sr_state_e;
endpackage

// File: rtl/i2c_sr_sync.sv
module i2c_sr_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  localparam int unsigned DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[DEPTH-2:0], din[g]};
    end
    assign lvl[g]  = pipe[STAGES-1];
    assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
  end
endmodule

// File: rtl/i2c_sr_regs.sv
module i2c_sr_regs
  import i2c_sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [STAT_W-1:0] stat_in,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] rd_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (uvlo)  ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  assign rd_byte = {ctrl_q, stat_in};
endmodule

// File: rtl/i2c_sr_fsm.sv
module i2c_sr_fsm
  import i2c_sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [CTRL_W-1:0] wr_data
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  sr_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              rnw;
  logic              mack;
  logic              ack_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '1;
      rnw     <= 1'b0;
      mack    <= 1'b0;
      ack_drv <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else if (uvlo) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ack_drv <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        ack_drv <= 1'b0;
      end else if (bus_stop) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise && cnt < FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_ADDR) begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  ack_drv <= 1'b1;
                  rnw     <= shreg[0];
                  state   <= ST_AACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                wr_en   <= 1'b1;
                wr_data <= shreg[BYTE_W-1 -: CTRL_W];
                ack_drv <= 1'b1;
                state   <= ST_WACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              cnt     <= '0;
              if (rnw) begin
                tx    <= rd_byte;
                state <= ST_RDAT;
              end else begin
                state <= ST_WDAT;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              state   <= ST_SKIP;
            end
          end
          ST_RDAT: begin
            if (scl_rise && cnt < FULL) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                tx    <= '1;
                state <= ST_RACK;
              end else begin
                tx <= {tx[BYTE_W-2:0], 1'b1};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                tx    <= rd_byte;
                cnt   <= '0;
                state <= ST_RDAT;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_IDLE, ST_SKIP: begin
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe = ack_drv | ((state == ST_RDAT) & ~tx[BYTE_W-1]);
endmodule

// File: rtl/i2c_sysreg_slave.sv
module i2c_sysreg_slave
  import i2c_sr_pkg::*;
#(
  parameter logic [4:0]  ADDR_PREFIX = 5'b00010,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_strap,
  input  logic              uvlo,
  input  logic              flag_otemp,
  input  logic              flag_ovld,
  output logic [CTRL_W-1:0] ctrl_out
);
  localparam int unsigned SCL_IDX = 0;
  localparam int unsigned SDA_IDX = 1;

  logic [1:0]        s_lvl;
  logic [1:0]        s_rise;
  logic [1:0]        s_fall;
  logic              bus_start;
  logic              bus_stop;
  logic [DEV_W-1:0]  dev_addr;
  logic [BYTE_W-1:0] rd_byte;
  logic              wr_en;
  logic [CTRL_W-1:0] wr_data;

  i2c_sr_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sda_i, scl_i}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  assign bus_start = s_lvl[SCL_IDX] & s_fall[SDA_IDX];
  assign bus_stop  = s_lvl[SCL_IDX] & s_rise[SDA_IDX];
  assign dev_addr  = {ADDR_PREFIX, addr_strap};

  i2c_sr_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo     (uvlo),
    .scl_rise (s_rise[SCL_IDX]),
    .scl_fall (s_fall[SCL_IDX]),
    .sda_lvl  (s_lvl[SDA_IDX]),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .dev_addr (dev_addr),
    .rd_byte  (rd_byte),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_data  (wr_data)
  );

  i2c_sr_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .uvlo   (uvlo),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .stat_in({flag_otemp, flag_ovld}),
    .ctrl_q (ctrl_out),
    .rd_byte(rd_byte)
  );
endmodule

// File: rtl/i2c_sysreg_slave_chk.sv
module i2c_sysreg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       uvlo,
  input logic       sda_oe,
  input logic       wr_en,
  input logic [5:0] ctrl_out
);
  a_r8_lockout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (ctrl_out == 6'd0));

  a_r8_lockout_silent: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !sda_oe);

  a_r9_drive_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !uvlo) |=> $stable(ctrl_out));

  a_r8_commit_not_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(uvlo));
endmodule

bind i2c_sysreg_slave i2c_sysreg_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .uvlo    (uvlo),
  .sda_oe  (sda_oe),
  .wr_en   (wr_en),
  .ctrl_out(ctrl_out)
);

// File: tb/i2c_sysreg_slave_bench.sv
module i2c_sysreg_slave_bench;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [1:0] strap = 2'b00;
  logic       uvlo = 1'b0;
  logic       f_ot = 1'b0;
  logic       f_ol = 1'b0;
  logic       sda_oe;
  logic [5:0] ctrl_out;
  logic       sda_line;
  logic       done = 1'b0;
  logic       oe_prev = 1'b0;
  int         checks = 0;
  int         errors = 0;
  int         drive_viol = 0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_sysreg_slave u_i2c_sysreg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .addr_strap(strap),
    .uvlo      (uvlo),
    .flag_otemp(f_ot),
    .flag_ovld (f_ol),
    .ctrl_out  (ctrl_out)
  );

  // R9 monitor: SDA drive must never begin while SCL is high
  always @(posedge clk) begin
    if (rst_n && sda_oe && !oe_prev && m_scl) drive_viol <= drive_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; wt(Q);
    m_scl = 1'b1; wt(Q);
    s = sda_line; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic more, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(~more, s);
  endtask

  task automatic write_txn(input logic [6:0] a, input logic [7:0] d, output logic aa, output logic da);
    bus_start();
    send_byte({a, 1'b0}, aa);
    send_byte(d, da);
    bus_stop();
  endtask

  task automatic read_one(input logic [6:0] a, output logic aa, output logic [7:0] d);
    bus_start();
    send_byte({a, 1'b1}, aa);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk(ctrl_out == 6'd0, "R1 ctrl after reset", ctrl_out, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
  endtask

  task automatic t_write_read();
    logic aa, da;
    logic [7:0] d;
    strap = 2'b00; f_ot = 1'b1; f_ol = 1'b0;
    write_txn(7'h08, 8'hFF, aa, da);
    chk(aa, "R3 address ack on write", aa, 1);
    chk(da, "R5 data ack", da, 1);
    chk(ctrl_out == 6'h3F, "R5 ctrl after 0xFF", ctrl_out, 6'h3F);
    read_one(7'h08, aa, d);
    chk(aa, "R2 read address ack", aa, 1);
    chk(d == 8'hFE, "R6 read byte with flags 10", d, 8'hFE);
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
  endtask

  task automatic t_low_bits_dropped();
    logic aa, da;
    logic [7:0] d;
    f_ot = 1'b0; f_ol = 1'b1;
    write_txn(7'h08, 8'hA6, aa, da);
    chk(ctrl_out == 6'h29, "R5 bits 1..0 discarded", ctrl_out, 6'h29);
    read_one(7'h08, aa, d);
    chk(d == 8'hA5, "R6 flags replace low bits", d, 8'hA5);
  endtask

  task automatic t_multi_read();
    logic aa, s;
    logic [7:0] d1, d2, d3;
    f_ot = 1'b0; f_ol = 1'b0;
    bus_start();
    send_byte({7'h08, 1'b1}, aa);
    recv_byte(1'b1, d1);
    f_ot = 1'b1; f_ol = 1'b1;
    recv_byte(1'b1, d2);
    recv_byte(1'b0, d3);
    chk(d1 == 8'hA4, "R6 first byte", d1, 8'hA4);
    chk(d2 == 8'hA4, "R6 flags held from load", d2, 8'hA4);
    chk(d3 == 8'hA7, "R7 third byte after acks", d3, 8'hA7);
    bit_io(1'b1, s);
    chk(s == 1'b1, "R7 passive after nack", s, 1);
    bus_stop();
  endtask

  task automatic t_strap();
    logic aa, da;
    strap = 2'b10;
    write_txn(7'h0A, 8'h54, aa, da);
    chk(aa && da, "R2 strap 10 address", {aa, da}, 2'b11);
    chk(ctrl_out == 6'h15, "R2 strap write lands", ctrl_out, 6'h15);
    write_txn(7'h08, 8'hFF, aa, da);
    chk(!aa, "R4 mismatch no ack", aa, 0);
    chk(!da, "R4 data after mismatch no ack", da, 0);
    chk(ctrl_out == 6'h15, "R4 ctrl untouched", ctrl_out, 6'h15);
    strap = 2'b00;
  endtask

  task automatic t_second_byte();
    logic aa, da, db;
    bus_start();
    send_byte({7'h08, 1'b0}, aa);
    send_byte(8'hC0, da);
    send_byte(8'h00, db);
    bus_stop();
    chk(da, "R5 first byte ack", da, 1);
    chk(!db, "R5 second byte nack", db, 0);
    chk(ctrl_out == 6'h30, "R5 second byte no effect", ctrl_out, 6'h30);
  endtask

  task automatic t_abort_restart();
    logic aa, s;
    bus_start();
    send_byte({7'h08, 1'b0}, aa);
    for (int i = 0; i < 4; i++) bit_io(1'b1, s);
    bus_stop();
    chk(ctrl_out == 6'h30, "R10 stop mid byte no update", ctrl_out, 6'h30);
    bus_start();
    for (int i = 0; i < 3; i++) bit_io(1'b0, s);
    bus_start();
    send_byte({7'h08, 1'b0}, aa);
    send_byte(8'h0C, s);
    bus_stop();
    chk(aa && s, "R10 restart accepted", {aa, s}, 2'b11);
    chk(ctrl_out == 6'h03, "R10 write after restart", ctrl_out, 6'h03);
  endtask

  task automatic t_lockout();
    logic aa, da;
    logic [7:0] d;
    uvlo = 1'b1; wt(3);
    chk(ctrl_out == 6'd0, "R8 lockout clears", ctrl_out, 0);
    write_txn(7'h08, 8'hFC, aa, da);
    chk(!aa, "R8 no ack in lockout", aa, 0);
    chk(ctrl_out == 6'd0, "R8 held zero", ctrl_out, 0);
    uvlo = 1'b0; f_ot = 1'b0; f_ol = 1'b0;
    read_one(7'h08, aa, d);
    chk(aa && d == 8'h00, "R8 zero after release", {aa, d}, 9'h100);
  endtask

  task automatic t_collide();
    logic aa, s;
    logic [7:0] v;
    write_txn(7'h08, 8'hFC, aa, s);
    chk(ctrl_out == 6'h3F, "R5 preload", ctrl_out, 6'h3F);
    v = 8'h54;
    bus_start();
    send_byte({7'h08, 1'b0}, aa);
    for (int i = 7; i >= 1; i--) bit_io(v[i], s);
    m_sda = v[0]; wt(Q);
    m_scl = 1'b1; wt(2 * Q);
    uvlo = 1'b1;
    m_scl = 1'b0; wt(Q);
    bit_io(1'b1, s);
    chk(s == 1'b1, "R8 collision no ack", s, 1);
    chk(ctrl_out == 6'd0, "R8 collision lockout wins", ctrl_out, 0);
    uvlo = 1'b0;
    bus_stop();
    wt(2);
    chk(ctrl_out == 6'd0, "R8 no late commit", ctrl_out, 0);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_write_read();
    t_low_bits_dropped();
    t_multi_read();
    t_strap();
    t_second_byte();
    t_abort_restart();
    t_lockout();
    t_collide();
    chk(drive_viol == 0, "R9 drive began with SCL high", drive_viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule